// File: doc/BRIEF.md
# Speed-Change Stall Recovery Guard

This block watches a serial link for one known failure: the link training state machine gets stuck while it moves to the higher signalling rate. The receiver never reports valid data, and the state machine stays in its receiver-lock recovery state. On each periodic check the guard looks at three things: a link-down indication, the 6-bit training state code and the PHY receive-valid bit. When it sees the stuck pattern, it pushes the PHY receive path through a forced restart.

The restart has two halves. The guard first reads the PHY receive-override register, sets two enable bits and writes the value back. It then holds that override for a fixed window. After the window it reads the register again, clears the same two bits and writes it back. Every other bit of the register is left as it was read. All PHY accesses go out as single requests on a simple register-access interface. A request is held until the far side responds, and a response can carry an error flag.

Each completed restart gives a one-cycle event pulse and bumps a saturating event counter. An error response stops the sequence and sets a sticky error flag.

Top module: `spd_stall_guard`

## Requirements
- R1: While `link_down` is 1, a `check_tick` starts nothing: no request is issued and no counter changes.
- R2: A check starts a recovery only if, at the tick, `ltssm_state` equals STUCK_CODE (0x0D by default) and `rx_valid` is 0. Any other state code, or `rx_valid` at 1, leaves the guard idle.
- R3: A recovery first reads address OVR_ADDR (0x1005 by default). It then writes the same address with the read value OR OVR_MASK (bits 5 and 3, 0x0028).
- R4: The second read request appears exactly HOLD_CYCLES clock cycles after the edge that accepts the first write's response.
- R5: After the window, the guard reads OVR_ADDR again and writes back the read value AND NOT OVR_MASK. All other bits are kept.
- R6: A request holds `req_valid`, `req_write`, `req_addr` and `req_wdata` steady until the cycle `resp_valid` is 1. Each response ends exactly one request.
- R7: A `check_tick` that arrives while a recovery is in progress has no effect.
- R8: When the final write's response arrives without error, `recov_pulse` is 1 for one cycle and `recov_count` rises by one. The count saturates at all ones.
- R9: A response with `resp_err` = 1 ends the recovery at once. No further request is issued, `recov_count` does not change, and `err_flag` goes to 1 and stays there until reset.
- R10: After reset, `req_valid`, `recov_pulse`, `err_flag` and `recov_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| check_tick | input | 1 | Periodic one-cycle check trigger |
| link_down | input | 1 | Link-down debug indication; suppresses checks |
| ltssm_state | input | STATE_W | Current training state code |
| rx_valid | input | 1 | PHY receive-valid status |
| req_valid | output | 1 | Register access request pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | ADDR_W | PHY register address |
| req_wdata | output | DATA_W | Write data |
| resp_valid | input | 1 | Response for the pending request |
| resp_rdata | input | DATA_W | Read data |
| resp_err | input | 1 | Response error |
| recov_pulse | output | 1 | One-cycle recovery completion pulse |
| recov_count | output | CNT_W | Saturating recovery count |
| err_flag | output | 1 | Sticky access error flag |

## Verification
The bench builds the guard with HOLD_CYCLES = 40 instead of a real 2 ms window. This lets it measure the exact hold interval and run several full recoveries in a short run. CNT_W = 2 puts the counter's saturation at three, so a fourth recovery exercises it. The address, mask and stuck code keep their defaults, so the read-modify-write values the bench expects use bits 5 and 3 of register 0x1005.

// File: rtl/spd_guard_pkg.sv
`timescale 1ns/1ps
package spd_guard_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_SET  = 3'd1,
        ST_WR_SET  = 3'd2,
        ST_HOLD    = 3'd3,
        ST_RD_CLR  = 3'd4,
        ST_WR_CLR  = 3'd5
    } guard_state_e;

endpackage

// File: rtl/spd_stall_detect.sv
`timescale 1ns/1ps
module spd_stall_detect #(
    parameter int                   STATE_W    = 6,
    parameter logic [STATE_W-1:0]   STUCK_CODE = 6'h0D
) (
    input  logic               link_down,
    input  logic [STATE_W-1:0] ltssm_state,
    input  logic               rx_valid,
    output logic               stuck
);

    always_comb begin
        stuck = !link_down && !rx_valid && (ltssm_state == STUCK_CODE);
    end

endmodule

// File: rtl/spd_hold_timer.sv
`timescale 1ns/1ps
module spd_hold_timer #(
    parameter int HOLD_CYCLES = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);

    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = '0;
        end else if (tmr_q.run) begin
            if (tmr_q.cnt == LAST) begin
                tmr_d.run = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign done = tmr_q.run && (tmr_q.cnt == LAST);

endmodule

// File: rtl/spd_sat_counter.sv
`timescale 1ns/1ps
module spd_sat_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (inc && (count_q != {CNT_W{1'b1}})) begin
            count_d = count_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count = count_q;

endmodule

// File: rtl/spd_stall_guard.sv
`timescale 1ns/1ps
module spd_stall_guard
    import spd_guard_pkg::*;
#(
    parameter int                 STATE_W     = 6,
    parameter logic [STATE_W-1:0] STUCK_CODE  = 6'h0D,
    parameter int                 ADDR_W      = 16,
    parameter int                 DATA_W      = 16,
    parameter logic [ADDR_W-1:0]  OVR_ADDR    = 16'h1005,
    parameter logic [DATA_W-1:0]  OVR_MASK    = 16'h0028,
    parameter int                 HOLD_CYCLES = 200000,
    parameter int                 CNT_W       = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               check_tick,
    input  logic               link_down,
    input  logic [STATE_W-1:0] ltssm_state,
    input  logic               rx_valid,
    output logic               req_valid,
    output logic               req_write,
    output logic [ADDR_W-1:0]  req_addr,
    output logic [DATA_W-1:0]  req_wdata,
    input  logic               resp_valid,
    input  logic [DATA_W-1:0]  resp_rdata,
    input  logic               resp_err,
    output logic               recov_pulse,
    output logic [CNT_W-1:0]   recov_count,
    output logic               err_flag
);

    typedef struct packed {
        guard_state_e      st;
        logic [DATA_W-1:0] data;
        logic              err;
        logic              pulse;
    } regs_t;

    regs_t r_d, r_q;

    logic stuck;
    logic hold_start;
    logic hold_done;
    logic evt_inc;

    spd_stall_detect #(
        .STATE_W   (STATE_W),
        .STUCK_CODE(STUCK_CODE)
    ) i_detect (
        .link_down  (link_down),
        .ltssm_state(ltssm_state),
        .rx_valid   (rx_valid),
        .stuck      (stuck)
    );

    spd_hold_timer #(
        .HOLD_CYCLES(HOLD_CYCLES)
    ) i_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(hold_start),
        .done (hold_done)
    );

    spd_sat_counter #(
        .CNT_W(CNT_W)
    ) i_count (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (evt_inc),
        .count(recov_count)
    );

    always_comb begin
        r_d        = r_q;
        r_d.pulse  = 1'b0;
        hold_start = 1'b0;
        evt_inc    = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (check_tick && stuck) begin
                    r_d.st = ST_RD_SET;
                end
            end
            ST_RD_SET: begin
                if (resp_valid) begin
                    if (resp_err) begin
                        r_d.err = 1'b1;
                        r_d.st  = ST_IDLE;
                    end else begin
                        r_d.data = resp_rdata | OVR_MASK;
                        r_d.st   = ST_WR_SET;
                    end
                end
            end
            ST_WR_SET: begin
                if (resp_valid) begin
                    if (resp_err) begin
                        r_d.err = 1'b1;
                        r_d.st  = ST_IDLE;
                    end else begin
                        hold_start = 1'b1;
                        r_d.st     = ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
                if (hold_done) begin
                    r_d.st = ST_RD_CLR;
                end
            end
            ST_RD_CLR: begin
                if (resp_valid) begin
                    if (resp_err) begin
                        r_d.err = 1'b1;
                        r_d.st  = ST_IDLE;
                    end else begin
                        r_d.data = resp_rdata & ~OVR_MASK;
                        r_d.st   = ST_WR_CLR;
                    end
                end
            end
            ST_WR_CLR: begin
                if (resp_valid) begin
                    if (resp_err) begin
                        r_d.err = 1'b1;
                    end else begin
                        r_d.pulse = 1'b1;
                        evt_inc   = 1'b1;
                    end
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, data: '0, err: 1'b0, pulse: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_valid   = (r_q.st == ST_RD_SET) || (r_q.st == ST_WR_SET) ||
                         (r_q.st == ST_RD_CLR) || (r_q.st == ST_WR_CLR);
    assign req_write   = (r_q.st == ST_WR_SET) || (r_q.st == ST_WR_CLR);
    assign req_addr    = OVR_ADDR;
    assign req_wdata   = r_q.data;
    assign recov_pulse = r_q.pulse;
    assign err_flag    = r_q.err;

endmodule

// File: rtl/spd_stall_guard_chk.sv
`timescale 1ns/1ps
module spd_stall_guard_chk
    import spd_guard_pkg::*;
#(
    parameter int                 STATE_W    = 6,
    parameter logic [STATE_W-1:0] STUCK_CODE = 6'h0D,
    parameter int                 DATA_W     = 16,
    parameter int                 CNT_W      = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               check_tick,
    input logic               link_down,
    input logic [STATE_W-1:0] ltssm_state,
    input logic               req_valid,
    input logic               req_write,
    input logic [DATA_W-1:0]  req_wdata,
    input logic               resp_valid,
    input logic               resp_err,
    input logic               recov_pulse,
    input logic [CNT_W-1:0]   recov_count,
    input logic               err_flag,
    input guard_state_e       state
);

    assert_down_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && check_tick && link_down) |=> (state == ST_IDLE));

    assert_other_state_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && check_tick && ltssm_state != STUCK_CODE) |=> !req_valid);

    assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !resp_valid) |=>
        (req_valid && $stable(req_write) && $stable(req_wdata)));

    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        recov_pulse |=> !recov_pulse);

    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        recov_pulse |-> (recov_count == $past(recov_count) + 1'b1 ||
                         recov_count == {CNT_W{1'b1}}));

    assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !recov_pulse |-> $stable(recov_count));

    assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $past(resp_valid && resp_err));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

endmodule

bind spd_stall_guard spd_stall_guard_chk #(
    .STATE_W   (STATE_W),
    .STUCK_CODE(STUCK_CODE),
    .DATA_W    (DATA_W),
    .CNT_W     (CNT_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .check_tick (check_tick),
    .link_down  (link_down),
    .ltssm_state(ltssm_state),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_wdata  (req_wdata),
    .resp_valid (resp_valid),
    .resp_err   (resp_err),
    .recov_pulse(recov_pulse),
    .recov_count(recov_count),
    .err_flag   (err_flag),
    .state      (r_q.st)
);

// File: tb/test_spd_stall_guard.sv
`timescale 1ns/1ps
module test_spd_stall_guard;

    localparam int HOLD = 40;
    localparam int CW   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        check_tick = 1'b0;
    logic        link_down = 1'b0;
    logic [5:0]  ltssm_state = 6'h00;
    logic        rx_valid = 1'b1;
    logic        req_valid, req_write;
    logic [15:0] req_addr, req_wdata;
    logic        resp_valid = 1'b0;
    logic [15:0] resp_rdata = 16'h0;
    logic        resp_err = 1'b0;
    logic        recov_pulse;
    logic [CW-1:0] recov_count;
    logic        err_flag;

    always #5 clk = ~clk;

    spd_stall_guard #(.HOLD_CYCLES(HOLD), .CNT_W(CW)) i_spd_stall_guard (
        .clk(clk), .rst_n(rst_n), .check_tick(check_tick), .link_down(link_down),
        .ltssm_state(ltssm_state), .rx_valid(rx_valid),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .resp_err(resp_err), .recov_pulse(recov_pulse), .recov_count(recov_count),
        .err_flag(err_flag)
    );

    typedef struct {
        logic        wr;
        logic [15:0] addr;
        logic [15:0] wdata;
        logic [15:0] rdata;
        logic        err;
    } txn_t;

    txn_t exp_q[$];
    int checks = 0;
    int failures = 0;
    int n_req = 0;
    int pulses = 0;
    int gap = 0;
    int last_gap = -1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor / responder: pops expected requests and answers them
    always @(negedge clk) begin
        if (rst_n) begin
            if (recov_pulse) pulses++;
            if (!req_valid) gap++;
            if (resp_valid) begin
                resp_valid = 1'b0;
                resp_err   = 1'b0;
            end else if (req_valid) begin
                txn_t t;
                n_req++;
                if (!req_write) last_gap = gap;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected request", int'(req_addr), 0);
                    resp_rdata = 16'h0;
                    resp_err   = 1'b0;
                end else begin
                    t = exp_q.pop_front();
                    check(req_write == t.wr, "R6 request kind", int'(req_write), int'(t.wr));
                    check(req_addr == t.addr, "R3/R5 request address", int'(req_addr), int'(t.addr));
                    if (t.wr)
                        check(req_wdata == t.wdata, "R3/R5 write data", int'(req_wdata), int'(t.wdata));
                    resp_rdata = t.rdata;
                    resp_err   = t.err;
                end
                resp_valid = 1'b1;
                gap = 0;
            end
        end
    end

    task automatic push(input logic wr, input logic [15:0] wd, input logic [15:0] rd, input logic er);
        txn_t t;
        t.wr = wr; t.addr = 16'h1005; t.wdata = wd; t.rdata = rd; t.err = er;
        exp_q.push_back(t);
    endtask

    task automatic tick(input logic ld, input logic [5:0] st, input logic rv);
        @(negedge clk);
        link_down = ld; ltssm_state = st; rx_valid = rv; check_tick = 1'b1;
        @(negedge clk);
        check_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        idle(6);
    endtask

    task automatic recovery(input logic [15:0] rd1, input logic [15:0] rd2);
        push(1'b0, 16'h0, rd1, 1'b0);
        push(1'b1, rd1 | 16'h0028, 16'h0, 1'b0);
        push(1'b0, 16'h0, rd2, 1'b0);
        push(1'b1, rd2 & ~16'h0028, 16'h0, 1'b0);
        tick(1'b0, 6'h0D, 1'b0);
        drain();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R10 reset state
        check(req_valid == 1'b0, "R10 req_valid", int'(req_valid), 0);
        check(recov_pulse == 1'b0, "R10 recov_pulse", int'(recov_pulse), 0);
        check(err_flag == 1'b0, "R10 err_flag", int'(err_flag), 0);
        check(recov_count == 0, "R10 recov_count", int'(recov_count), 0);

        // R1 link down suppresses the check
        tick(1'b1, 6'h0D, 1'b0);
        idle(10);
        check(n_req == 0, "R1 no request while link down", n_req, 0);
        check(recov_count == 0, "R1 count unchanged", int'(recov_count), 0);

        // R2 wrong state, or receive valid present
        tick(1'b0, 6'h0C, 1'b0);
        idle(6);
        tick(1'b0, 6'h0D, 1'b1);
        idle(6);
        check(n_req == 0, "R2 no request outside stuck pattern", n_req, 0);

        // R3 R4 R5 R7 R8: full recovery with an extra tick during the hold
        push(1'b0, 16'h0, 16'h1234, 1'b0);
        push(1'b1, 16'h123C, 16'h0, 1'b0);
        push(1'b0, 16'h0, 16'hFFFF, 1'b0);
        push(1'b1, 16'hFFD7, 16'h0, 1'b0);
        tick(1'b0, 6'h0D, 1'b0);
        idle(12);
        tick(1'b0, 6'h0D, 1'b0);
        drain();
        idle(10);
        check(n_req == 4, "R7 tick during recovery ignored", n_req, 4);
        check(last_gap == HOLD, "R4 hold window length", last_gap, HOLD);
        check(pulses == 1, "R8 one pulse", pulses, 1);
        check(recov_count == 1, "R8 count after first", int'(recov_count), 1);
        check(err_flag == 1'b0, "R9 no error on clean run", int'(err_flag), 0);

        // R8 saturation at 3 with CNT_W = 2
        recovery(16'h0000, 16'h0028);
        recovery(16'hA5A5, 16'h5A5A);
        check(recov_count == 3, "R8 count reaches max", int'(recov_count), 3);
        recovery(16'h0008, 16'h0020);
        check(recov_count == 3, "R8 count saturates", int'(recov_count), 3);
        check(pulses == 4, "R8 pulse per recovery", pulses, 4);
        check(n_req == 16, "R6 one request per response", n_req, 16);

        // R9 error on the first read aborts
        push(1'b0, 16'h0, 16'h7777, 1'b1);
        tick(1'b0, 6'h0D, 1'b0);
        drain();
        idle(HOLD + 10);
        check(n_req == 17, "R9 no request after error", n_req, 17);
        check(err_flag == 1'b1, "R9 error flag set", int'(err_flag), 1);
        check(pulses == 4, "R9 no pulse on abort", pulses, 4);
        check(recov_count == 3, "R9 count unchanged", int'(recov_count), 3);

        // R9 error flag sticky across a later good recovery
        recovery(16'h0100, 16'h0100);
        check(err_flag == 1'b1, "R9 error flag sticky", int'(err_flag), 1);
        check(pulses == 5, "R8 recovery after abort", pulses, 5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule